// File: doc/BRIEF.md
# DMA Channel Programming Port

This block is the programming front end of a sixteen-channel DMA controller. Software reaches it through two byte-wide ports. A byte written to the command port names an operation and a channel. Later accesses to the execute port move that operation's parameter bytes one at a time, least significant byte first. An internal byte pointer keeps track of which byte comes next.

For each channel the block keeps a memory address, a remaining transfer count, an I/O port number, a mode byte and a mask bit. It gives the transfer engine an armed flag for every channel. For the channel the engine names, it also presents the address, port and mode. When the engine signals a decrement, the block steps that channel's count and address, and it raises a terminal-count pulse when the count runs out. Bus arbitration and the data movement itself belong to other blocks.

Top module: `dma_cmd_regfile`

## Requirements
- R1: A command-port byte carries the operation in bits 7:4 and the channel number in bits 3:0. The opcodes are: 0x0 set I/O port, 0x2 set address, 0x3 read address, 0x4 set count, 0x5 read count, 0x7 set mode, 0x9 mask, 0xA unmask.
- R2: Opcode 0x0 loads the channel's 16-bit I/O port from two execute-port writes, low byte first. The value appears on `engPort` when `xferCh` selects that channel.
- R3: Opcode 0x2 loads the channel's 24-bit address from three execute-port writes. The bytes arrive in the order bits 7:0, then 15:8, then 23:16.
- R4: Opcode 0x4 loads the 16-bit count from two execute-port writes, low byte first. The count holds the number of units minus one. Opcode 0x5 returns the current count on two execute-port reads, low byte first.
- R5: Opcode 0x3 returns the current address on three execute-port reads, low byte first. Every command-port write resets the byte pointer to zero. Execute-port reads beyond an operation's bytes return 0x00, and writes beyond them are ignored.
- R6: Opcode 0x7 loads the mode byte from one execute-port write. The bits are: bit 2 enable, bit 3 read direction (clear means write), bit 0 I/O-register transfer, bit 6 16-bit units. A channel is armed when it is unmasked and its mode bit 2 is set.
- R7: Opcode 0x9 masks the channel and opcode 0xA unmasks it; neither takes execute bytes. Writes to the port, address, count or mode registers take effect only while the channel is masked.
- R8: Opcodes 0x1, 0x6, 0x8 and 0xB to 0xF change no state. Execute accesses that follow them read 0x00 and write nothing.
- R9: After reset every channel is masked, all registers are zero, `armed` is zero and `exeRData` is 0x00.
- R10: A `xferDec` pulse on an armed channel `xferCh` decrements its count. It advances the address by 1 in 8-bit mode and by 2 when mode bit 6 is set. A pulse on a channel that is not armed is ignored.
- R11: A decrement that finds the count at zero wraps the count to 0xFFFF. It raises `termCount` for exactly the next cycle. Any other decrement leaves `termCount` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cmdWe | input | 1 | Command-port write strobe |
| cmdData | input | 8 | Command byte: operation and channel |
| exeWe | input | 1 | Execute-port write strobe |
| exeRe | input | 1 | Execute-port read strobe; advances the pointer |
| exeWData | input | 8 | Execute-port write byte |
| exeRData | output | 8 | Execute-port read byte, valid while exeRe is high |
| xferDec | input | 1 | Decrement request from the transfer engine |
| xferCh | input | 4 | Channel served by the transfer engine |
| armed | output | 16 | Armed flag for each channel |
| termCount | output | 1 | Terminal-count pulse |
| engAddr | output | 24 | Current address of channel xferCh |
| engPort | output | 16 | I/O port of channel xferCh |
| engMode | output | 8 | Mode byte of channel xferCh |

## Verification
The read byte on `exeRData` is combinational: it is sampled while `exeRe` is held, before the edge that advances the pointer. Register writes, mask changes and decrements land on the clock edge that samples the strobe. The bench therefore samples `armed`, `engAddr`, `engPort` and `engMode` at the falling edge that follows that rising edge. `termCount` comes from a register set on the decrement edge. It is checked high at the next falling edge and low one cycle later. All inputs change on falling edges, so every sample falls half a period away from the active edge.

// File: rtl/dcr_pkg.sv
package dcr_pkg;

  typedef enum logic [3:0] {
    OP_SET_PORT = 4'h0,
    OP_SET_ADDR = 4'h2,
    OP_GET_ADDR = 4'h3,
    OP_SET_CNT  = 4'h4,
    OP_GET_CNT  = 4'h5,
    OP_SET_MODE = 4'h7,
    OP_MASK     = 4'h9,
    OP_UNMASK   = 4'hA,
    OP_IDLE     = 4'hF
  } dcr_op_e;

  localparam int MODE_IO_BIT   = 0;
  localparam int MODE_EN_BIT   = 2;
  localparam int MODE_RD_BIT   = 3;
  localparam int MODE_WIDE_BIT = 6;

  // strobes from control to datapath
  typedef struct packed {
    logic       wrPort;
    logic       wrAddr;
    logic       wrCnt;
    logic       wrMode;
    logic       setMask;
    logic       clrMask;
    logic       rdAddr;
    logic       rdCnt;
    logic [1:0] idx;
    logic [7:0] data;
  } dcr_strobe_t;

endpackage

// File: rtl/dcr_ctrl.sv
module dcr_ctrl
  import dcr_pkg::*;
#(
  parameter int CH_W = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            cmdWe,
  input  logic [7:0]      cmdData,
  input  logic            exeWe,
  input  logic            exeRe,
  input  logic [7:0]      exeWData,
  output dcr_strobe_t     stb,
  output logic [CH_W-1:0] stbCh
);

  logic [3:0]      opQ;
  logic [CH_W-1:0] selQ;
  logic [1:0]      ptrQ;
  logic            exeAct;
  logic            inRange;
  logic [3:0]      cmdOp;

  // number of execute bytes each operation consumes
  function automatic logic [1:0] opBytes(input logic [3:0] op);
    case (op)
      OP_SET_PORT: opBytes = 2'd2;
      OP_SET_ADDR: opBytes = 2'd3;
      OP_GET_ADDR: opBytes = 2'd3;
      OP_SET_CNT:  opBytes = 2'd2;
      OP_GET_CNT:  opBytes = 2'd2;
      OP_SET_MODE: opBytes = 2'd1;
      default:     opBytes = 2'd0;
    endcase
  endfunction

  assign cmdOp   = cmdData[7:4];
  assign exeAct  = (exeWe | exeRe) & ~cmdWe;
  assign inRange = ptrQ < opBytes(opQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opQ  <= OP_IDLE;
      selQ <= '0;
      ptrQ <= '0;
    end else if (cmdWe) begin
      opQ  <= cmdOp;
      selQ <= cmdData[CH_W-1:0];
      ptrQ <= '0;
    end else if (exeAct && ptrQ != 2'd3) begin
      ptrQ <= ptrQ + 2'd1;
    end
  end

  always_comb begin
    stb         = '0;
    stb.idx     = ptrQ;
    stb.data    = exeWData;
    stb.wrPort  = exeWe & ~cmdWe & inRange & (opQ == OP_SET_PORT);
    stb.wrAddr  = exeWe & ~cmdWe & inRange & (opQ == OP_SET_ADDR);
    stb.wrCnt   = exeWe & ~cmdWe & inRange & (opQ == OP_SET_CNT);
    stb.wrMode  = exeWe & ~cmdWe & inRange & (opQ == OP_SET_MODE);
    stb.rdAddr  = exeRe & ~cmdWe & inRange & (opQ == OP_GET_ADDR);
    stb.rdCnt   = exeRe & ~cmdWe & inRange & (opQ == OP_GET_CNT);
    stb.setMask = cmdWe & (cmdOp == OP_MASK);
    stb.clrMask = cmdWe & (cmdOp == OP_UNMASK);
  end

  // mask commands act on the channel in the command byte itself
  assign stbCh = cmdWe ? cmdData[CH_W-1:0] : selQ;

endmodule

// File: rtl/dcr_datapath.sv
module dcr_datapath
  import dcr_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int CH_W   = 4,
  parameter int ADDR_W = 24,
  parameter int CNT_W  = 16,
  parameter int PORT_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dcr_strobe_t       stb,
  input  logic [CH_W-1:0]   stbCh,
  input  logic              xferDec,
  input  logic [CH_W-1:0]   xferCh,
  output logic [7:0]        exeRData,
  output logic [NUM_CH-1:0] armed,
  output logic              termCount,
  output logic [ADDR_W-1:0] engAddr,
  output logic [PORT_W-1:0] engPort,
  output logic [7:0]        engMode
);

  localparam int ADDR_B = ADDR_W / 8;
  localparam int CNT_B  = CNT_W / 8;
  localparam int PORT_B = PORT_W / 8;

  logic [ADDR_W-1:0] addrQ [NUM_CH];
  logic [CNT_W-1:0]  cntQ  [NUM_CH];
  logic [PORT_W-1:0] portQ [NUM_CH];
  logic [7:0]        modeQ [NUM_CH];
  logic [NUM_CH-1:0] maskQ;
  logic              tcQ;
  logic              decOk;
  logic              selMasked;

  assign decOk     = xferDec & armed[xferCh];
  assign selMasked = maskQ[stbCh];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_CH; i++) begin
        addrQ[i] <= '0;
        cntQ[i]  <= '0;
        portQ[i] <= '0;
        modeQ[i] <= '0;
      end
      maskQ <= '1;
      tcQ   <= 1'b0;
    end else begin
      if (stb.setMask) maskQ[stbCh] <= 1'b1;
      if (stb.clrMask) maskQ[stbCh] <= 1'b0;
      if (selMasked) begin
        for (int b = 0; b < ADDR_B; b++)
          if (stb.wrAddr && stb.idx == 2'(b)) addrQ[stbCh][b*8 +: 8] <= stb.data;
        for (int b = 0; b < CNT_B; b++)
          if (stb.wrCnt && stb.idx == 2'(b)) cntQ[stbCh][b*8 +: 8] <= stb.data;
        for (int b = 0; b < PORT_B; b++)
          if (stb.wrPort && stb.idx == 2'(b)) portQ[stbCh][b*8 +: 8] <= stb.data;
        if (stb.wrMode) modeQ[stbCh] <= stb.data;
      end
      // writes need a masked channel, decrements an armed one: no overlap
      if (decOk) begin
        cntQ[xferCh]  <= cntQ[xferCh] - 1'b1;
        addrQ[xferCh] <= addrQ[xferCh] +
                         (modeQ[xferCh][MODE_WIDE_BIT] ? ADDR_W'(2) : ADDR_W'(1));
      end
      tcQ <= decOk && (cntQ[xferCh] == '0);
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_arm
    assign armed[g] = ~maskQ[g] & modeQ[g][MODE_EN_BIT];
  end

  always_comb begin
    exeRData = 8'h00;
    for (int b = 0; b < ADDR_B; b++)
      if (stb.rdAddr && stb.idx == 2'(b)) exeRData = addrQ[stbCh][b*8 +: 8];
    for (int b = 0; b < CNT_B; b++)
      if (stb.rdCnt && stb.idx == 2'(b)) exeRData = cntQ[stbCh][b*8 +: 8];
  end

  assign termCount = tcQ;
  assign engAddr   = addrQ[xferCh];
  assign engPort   = portQ[xferCh];
  assign engMode   = modeQ[xferCh];

endmodule

// File: rtl/dma_cmd_regfile.sv
module dma_cmd_regfile
  import dcr_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int ADDR_W = 24,
  parameter int CNT_W  = 16,
  parameter int PORT_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdWe,
  input  logic [7:0]        cmdData,
  input  logic              exeWe,
  input  logic              exeRe,
  input  logic [7:0]        exeWData,
  output logic [7:0]        exeRData,
  input  logic              xferDec,
  input  logic [3:0]        xferCh,
  output logic [NUM_CH-1:0] armed,
  output logic              termCount,
  output logic [ADDR_W-1:0] engAddr,
  output logic [PORT_W-1:0] engPort,
  output logic [7:0]        engMode
);

  localparam int CH_W = 4;

  dcr_strobe_t     stb;
  logic [CH_W-1:0] stbCh;

  dcr_ctrl #(.CH_W(CH_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdWe(cmdWe), .cmdData(cmdData),
    .exeWe(exeWe), .exeRe(exeRe), .exeWData(exeWData),
    .stb(stb), .stbCh(stbCh)
  );

  dcr_datapath #(
    .NUM_CH(NUM_CH), .CH_W(CH_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .PORT_W(PORT_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .stbCh(stbCh),
    .xferDec(xferDec), .xferCh(xferCh), .exeRData(exeRData),
    .armed(armed), .termCount(termCount),
    .engAddr(engAddr), .engPort(engPort), .engMode(engMode)
  );

endmodule

// File: rtl/dcr_checker.sv
module dcr_checker
  import dcr_pkg::*;
#(
  parameter int NUM_CH = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              cmdWe,
  input logic [7:0]        cmdData,
  input logic              xferDec,
  input logic              termCount,
  input logic [NUM_CH-1:0] armed,
  input logic [7:0]        exeRData,
  input dcr_strobe_t       stb
);

  logic unknownOp;
  assign unknownOp = cmdData[7:4] inside {4'h1, 4'h6, 4'h8, 4'hB, 4'hC, 4'hD, 4'hE, 4'hF};

  assert_mask_disarms_R7: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWe && cmdData[7:4] == 4'h9) |=> !armed[$past(cmdData[3:0])]);

  assert_unknown_stable_R8: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWe && unknownOp) |=> $stable(armed));

  assert_tc_follows_dec_R11: assert property (@(posedge clk) disable iff (!rstN)
    termCount |-> $past(xferDec));

  assert_single_strobe_R1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.wrPort, stb.wrAddr, stb.wrCnt, stb.wrMode,
              stb.setMask, stb.clrMask, stb.rdAddr, stb.rdCnt}));

  assert_idle_read_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.rdAddr || stb.rdCnt) |-> exeRData == 8'h00);

endmodule

bind dma_cmd_regfile dcr_checker #(.NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rstN(rstN), .cmdWe(cmdWe), .cmdData(cmdData),
  .xferDec(xferDec), .termCount(termCount), .armed(armed),
  .exeRData(exeRData), .stb(stb)
);

// File: tb/dma_cmd_regfile_tb.sv
module dma_cmd_regfile_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdWe = 1'b0;
  logic [7:0]  cmdData = 8'h00;
  logic        exeWe = 1'b0;
  logic        exeRe = 1'b0;
  logic [7:0]  exeWData = 8'h00;
  logic [7:0]  exeRData;
  logic        xferDec = 1'b0;
  logic [3:0]  xferCh = 4'h0;
  logic [15:0] armed;
  logic        termCount;
  logic [23:0] engAddr;
  logic [15:0] engPort;
  logic [7:0]  engMode;

  int  nChk = 0;
  int  nFail = 0;
  bit  done = 1'b0;

  always #10 clk = ~clk;

  dma_cmd_regfile u_dut (
    .clk(clk), .rstN(rstN), .cmdWe(cmdWe), .cmdData(cmdData),
    .exeWe(exeWe), .exeRe(exeRe), .exeWData(exeWData), .exeRData(exeRData),
    .xferDec(xferDec), .xferCh(xferCh), .armed(armed), .termCount(termCount),
    .engAddr(engAddr), .engPort(engPort), .engMode(engMode)
  );

  function automatic logic [23:0] expAddr(input int c);
    return 24'(32'h010203 * (c + 1));
  endfunction
  function automatic logic [15:0] expCnt(input int c);
    return 16'(16'h0100 + c * 7);
  endfunction
  function automatic logic [15:0] expPort(input int c);
    return 16'hA500 ^ 16'(c * 16'h0111);
  endfunction
  function automatic logic [7:0] expMode(input int c);
    if (c == 3) return 8'h08;
    return (c % 2 == 1) ? 8'h44 : 8'h0D;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cmd(input logic [3:0] op, input logic [3:0] ch);
    @(negedge clk); cmdData = {op, ch}; cmdWe = 1'b1;
    @(negedge clk); cmdWe = 1'b0;
  endtask

  task automatic exeW(input logic [7:0] b);
    @(negedge clk); exeWData = b; exeWe = 1'b1;
    @(negedge clk); exeWe = 1'b0;
  endtask

  task automatic exeR(output logic [7:0] v);
    @(negedge clk); exeRe = 1'b1; #2 v = exeRData;
    @(negedge clk); exeRe = 1'b0;
  endtask

  task automatic readAddr(input logic [3:0] ch, output logic [23:0] a);
    logic [7:0] b0, b1, b2;
    cmd(4'h3, ch); exeR(b0); exeR(b1); exeR(b2);
    a = {b2, b1, b0};
  endtask

  task automatic readCnt(input logic [3:0] ch, output logic [15:0] n);
    logic [7:0] b0, b1;
    cmd(4'h5, ch); exeR(b0); exeR(b1);
    n = {b1, b0};
  endtask

  task automatic decPulse(input logic [3:0] ch, output logic tcSeen);
    @(negedge clk); xferCh = ch; xferDec = 1'b1;
    @(negedge clk); xferDec = 1'b0; #2 tcSeen = termCount;
  endtask

  localparam logic [3:0] UNK [7] = '{4'h1, 4'h6, 4'h8, 4'hB, 4'hC, 4'hD, 4'hE};

  initial begin
    logic [23:0] a;
    logic [15:0] n;
    logic [7:0]  v;
    logic        tc;

    // reset state
    #35 ;
    check("R9 armed after reset", 32'(armed), 32'h0);
    check("R9 engAddr after reset", 32'(engAddr), 32'h0);
    check("R9 termCount after reset", 32'(termCount), 32'h0);
    rstN = 1'b1;
    readAddr(4'h7, a);
    check("R9 address register zero", 32'(a), 32'h0);
    exeR(v);
    check("R9 read past end zero", 32'(v), 32'h0);

    // program every channel while masked
    for (int c = 0; c < 16; c++) begin
      cmd(4'h0, 4'(c)); exeW(expPort(c)[7:0]); exeW(expPort(c)[15:8]);
      cmd(4'h2, 4'(c)); exeW(expAddr(c)[7:0]); exeW(expAddr(c)[15:8]); exeW(expAddr(c)[23:16]);
      exeW(8'hEE); // beyond three bytes: ignored (R5)
      cmd(4'h4, 4'(c)); exeW(expCnt(c)[7:0]); exeW(expCnt(c)[15:8]);
      cmd(4'h7, 4'(c)); exeW(expMode(c));
    end
    check("R7 nothing armed while masked", 32'(armed), 32'h0);

    for (int c = 0; c < 16; c++) begin
      readAddr(4'(c), a);
      check("R3/R5 address readback", 32'(a), 32'(expAddr(c)));
      exeR(v);
      check("R5 fourth address read zero", 32'(v), 32'h0);
      readCnt(4'(c), n);
      check("R4 count readback", 32'(n), 32'(expCnt(c)));
      @(negedge clk); xferCh = 4'(c); #2;
      check("R2 engPort", 32'(engPort), 32'(expPort(c)));
      check("R6 engMode", 32'(engMode), 32'(expMode(c)));
      check("R3 engAddr", 32'(engAddr), 32'(expAddr(c)));
    end

    // unmask all
    for (int c = 0; c < 16; c++) cmd(4'hA, 4'(c));
    #1 check("R6 armed pattern", 32'(armed), 32'h0000FFF7);

    // writes to unmasked channel ignored
    cmd(4'h2, 4'h0); exeW(8'hFF); exeW(8'hFF); exeW(8'hFF);
    cmd(4'h0, 4'h0); exeW(8'h11); exeW(8'h22);
    readAddr(4'h0, a);
    check("R7 unmasked address write ignored", 32'(a), 32'(expAddr(0)));
    @(negedge clk); xferCh = 4'h0; #2;
    check("R7 unmasked port write ignored", 32'(engPort), 32'(expPort(0)));

    // unknown opcodes
    foreach (UNK[k]) begin
      cmd(UNK[k], 4'h1); exeW(8'hFF); exeR(v);
      check("R8 unknown op read zero", 32'(v), 32'h0);
    end
    check("R8 armed unchanged", 32'(armed), 32'h0000FFF7);
    readAddr(4'h1, a);
    check("R8 address unchanged", 32'(a), 32'(expAddr(1)));

    // pointer restart on command write
    cmd(4'h3, 4'h2); exeR(v); exeR(v);
    cmd(4'h3, 4'h2); exeR(v);
    check("R5 pointer reset", 32'(v), 32'(expAddr(2)[7:0]));

    // mask / unmask
    cmd(4'h9, 4'h2);
    #1 check("R7 mask clears armed", 32'(armed[2]), 32'h0);
    cmd(4'hA, 4'h2);
    #1 check("R7 unmask rearms", 32'(armed[2]), 32'h1);

    // decrement, 8-bit channel 4 with count 1
    cmd(4'h9, 4'h4); cmd(4'h4, 4'h4); exeW(8'h01); exeW(8'h00); cmd(4'hA, 4'h4);
    decPulse(4'h4, tc);
    check("R11 no tc on nonzero count", 32'(tc), 32'h0);
    check("R10 8-bit address step", 32'(engAddr), 32'(expAddr(4) + 24'd1));
    readCnt(4'h4, n);
    check("R10 count decremented", 32'(n), 32'h0);
    decPulse(4'h4, tc);
    check("R11 tc on zero count", 32'(tc), 32'h1);
    @(negedge clk); #2;
    check("R11 tc one cycle", 32'(termCount), 32'h0);
    readCnt(4'h4, n);
    check("R11 count wraps", 32'(n), 32'hFFFF);

    // 16-bit channel 5
    decPulse(4'h5, tc);
    check("R10 16-bit address step", 32'(engAddr), 32'(expAddr(5) + 24'd2));
    readCnt(4'h5, n);
    check("R10 16-bit count", 32'(n), 32'(expCnt(5) - 16'd1));

    // not armed: channel 3 (enable clear) and masked channel 6
    decPulse(4'h3, tc);
    check("R10 unarmed no step", 32'(engAddr), 32'(expAddr(3)));
    cmd(4'h9, 4'h6);
    decPulse(4'h6, tc);
    check("R10 masked no step", 32'(engAddr), 32'(expAddr(6)));
    readCnt(4'h6, n);
    check("R10 masked count kept", 32'(n), 32'(expCnt(6)));

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      nChk++;
      nFail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
      $finish;
    end
  end

endmodule